// File: doc/BRIEF.md
# Power-Gating Trigger Controller

This block switches a set of power-gated domains on and off at the request of software. Software writes a 1 into a power-up trigger register or a power-down trigger register, with one bit for each domain. The controller then drives that domain's power-switch and isolation outputs through a timed sequence. When the sequence is finished, the controller clears the trigger bit, and software polls the register until the bit reads 0. Each domain also has a control register. Bit 0 of that register is the power-down enable, and it decides which of the two requests the domain will accept.

The controller runs one sequence at a time. When several requests are pending, it picks the lowest pending bit. If both requests are pending on the same bit, it serves the power-up request first. The two phases of a sequence are timed in ticks of a slow timing clock, modelled here as `TICK_DIV` cycles of `clk` each. The tick counts for each phase come from a timing register. Two domains have a USB PHY reset input, and their power-up trigger does not clear while that reset input is held high.

The sequencer has six states. `ST_IDLE` waits for a pending bit. From there it goes to `ST_UP_SW` for a power-up (switch closed, waiting the switch ticks) or to `ST_DN_ISO` for a power-down (isolation asserted, waiting the isolation ticks). `ST_UP_SW` moves to `ST_UP_ISO` when its count expires. `ST_UP_ISO` releases isolation on expiry and moves to `ST_FIN`. `ST_DN_ISO` opens the switch on expiry and moves to `ST_DN_SW`. `ST_DN_SW` moves to `ST_FIN` on expiry. `ST_FIN` clears the trigger bit and returns to `ST_IDLE`, unless a held PHY reset input keeps it waiting.

Top module: `pgt_ctrl`

## Requirements
- R1: After reset:
  - both trigger registers read 0;
  - the timing register reads 0x81;
  - every control register reads 0;
  - every `pwr_sw_on` bit is 0 and every `pwr_iso` bit is 1.
- R2: The register map is:
  - 0x000 is the power-up trigger register;
  - 0x004 is the power-down trigger register;
  - domain i's control register is at 0xC00 + 0x40·i, with the power-down enable in bit 0.
  
  Writing 1 to a power-up trigger bit sets it only if the domain's enable bit is 0. Writing 1 to a power-down trigger bit sets it only if the enable bit is 1. Otherwise the bit stays 0.
- R3: Trigger bits 4 and 5 can never be set, and writing them changes no output.
- R4: A power-up of domain d closes `pwr_sw_on[d]` on the edge after the trigger is captured. It releases `pwr_iso[d]` (SW+ISO)·TICK_DIV cycles later.
- R5: A power-down of domain d asserts `pwr_iso[d]` on the edge after the trigger is captured. It opens `pwr_sw_on[d]` ISO·TICK_DIV cycles later.
- R6: A trigger bit reads 1 from the cycle after it is written until the sequence ends. With no PHY hold, it first reads 0 (SW+ISO)·TICK_DIV + 2 cycles after the write edge.
- R7: Pending requests are served one at a time, lowest bit first. When both requests are pending on one bit, power-up is served before power-down.
- R8: Writing 1 to a trigger bit that is already pending has no effect. Writing 0 to a trigger bit never clears or cancels it.
- R9: While `phy_rst_held[0]` is 1, power-up trigger bit 2 does not clear. The same holds for `phy_rst_held[1]` and bit 3.
- R10: The timing register at 0x008 holds SW in bits [6:0] and ISO in bits [13:7]. A field value of 0 counts as one tick.
- R11: The outputs never show isolation released on a domain whose switch is open. At most one output bit changes per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| phy_rst_held | input | 2 | USB PHY reset held, for domains 2 and 3 |
| pwr_sw_on | output | 14 | Per-domain power switch closed |
| pwr_iso | output | 14 | Per-domain isolation asserted |

## Verification
The assertions assume three things about the inputs:
- the timing register is not rewritten while a sequence is running;
- accesses are single-cycle strobes;
- each PHY reset input holds its value for whole cycles.

The stimulus changes timing only after polling shows both trigger registers empty. It drives every input on the falling edge. It keeps a PHY reset input high across a pending power-up, then drops it, so that the wait in `ST_FIN` is exercised without leaving a request stranded.

// File: rtl/pgt_pkg.sv
`timescale 1ns/1ps
package pgt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UP_SW,
        ST_UP_ISO,
        ST_DN_ISO,
        ST_DN_SW,
        ST_FIN
    } seq_state_t;

    localparam int          ADDR_W      = 12;
    localparam int          TF_W        = 7;
    localparam logic [11:0] A_UP_TRIG   = 12'h000;
    localparam logic [11:0] A_DN_TRIG   = 12'h004;
    localparam logic [11:0] A_TIMING    = 12'h008;
    localparam logic [11:0] A_CTRL_BASE = 12'hC00;
    localparam logic [11:0] CTRL_STRIDE = 12'h040;
    localparam logic [13:0] TIMING_RST  = 14'h0081;
endpackage

// File: rtl/pgt_regs.sv
`timescale 1ns/1ps
module pgt_regs
    import pgt_pkg::*;
#(
    parameter int                 NUM_DOM    = 14,
    parameter logic [NUM_DOM-1:0] VALID_MASK = 14'h3FCF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_en,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_DOM-1:0] clr_up,
    input  logic [NUM_DOM-1:0] clr_dn,
    output logic [NUM_DOM-1:0] up_q,
    output logic [NUM_DOM-1:0] dn_q,
    output logic [TF_W-1:0]    sw_ticks,
    output logic [TF_W-1:0]    iso_ticks
);
    logic [NUM_DOM-1:0] pdn_en;
    logic [NUM_DOM-1:0] set_up, set_dn;
    logic               wr;

    assign wr = bus_en && bus_we;

    always_comb begin
        set_up = '0;
        set_dn = '0;
        if (wr && bus_addr == A_UP_TRIG)
            set_up = bus_wdata[NUM_DOM-1:0] & VALID_MASK & ~pdn_en & ~up_q;
        if (wr && bus_addr == A_DN_TRIG)
            set_dn = bus_wdata[NUM_DOM-1:0] & VALID_MASK & pdn_en & ~dn_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            up_q <= '0;
            dn_q <= '0;
        end else begin
            up_q <= (up_q | set_up) & ~clr_up;
            dn_q <= (dn_q | set_dn) & ~clr_dn;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_ticks  <= TIMING_RST[TF_W-1:0];
            iso_ticks <= TIMING_RST[2*TF_W-1:TF_W];
        end else if (wr && bus_addr == A_TIMING) begin
            sw_ticks  <= bus_wdata[TF_W-1:0];
            iso_ticks <= bus_wdata[2*TF_W-1:TF_W];
        end
    end

    for (genvar gi = 0; gi < NUM_DOM; gi++) begin : g_ctrl
        localparam logic [ADDR_W-1:0] MY_ADDR = A_CTRL_BASE + ADDR_W'(gi) * CTRL_STRIDE;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                pdn_en[gi] <= 1'b0;
            else if (wr && bus_addr == MY_ADDR)
                pdn_en[gi] <= bus_wdata[0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_UP_TRIG) bus_rdata[NUM_DOM-1:0] = up_q;
        if (bus_addr == A_DN_TRIG) bus_rdata[NUM_DOM-1:0] = dn_q;
        if (bus_addr == A_TIMING)  bus_rdata[2*TF_W-1:0]  = {iso_ticks, sw_ticks};
        for (int i = 0; i < NUM_DOM; i++)
            if (bus_addr == A_CTRL_BASE + ADDR_W'(i) * CTRL_STRIDE)
                bus_rdata[0] = pdn_en[i];
    end
endmodule

// File: rtl/pgt_delay.sv
`timescale 1ns/1ps
module pgt_delay #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - CW'(1);
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/pgt_seq.sv
`timescale 1ns/1ps
module pgt_seq
    import pgt_pkg::*;
#(
    parameter int NUM_DOM  = 14,
    parameter int TICK_DIV = 4,
    parameter int USB0_BIT = 2,
    parameter int USB1_BIT = 3,
    parameter int CW       = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_DOM-1:0] up_q,
    input  logic [NUM_DOM-1:0] dn_q,
    input  logic [TF_W-1:0]    sw_ticks,
    input  logic [TF_W-1:0]    iso_ticks,
    input  logic [1:0]         phy_hold,
    input  logic               expired,
    output logic               load,
    output logic [CW-1:0]      load_val,
    output logic [NUM_DOM-1:0] clr_up,
    output logic [NUM_DOM-1:0] clr_dn,
    output logic [NUM_DOM-1:0] sw_on,
    output logic [NUM_DOM-1:0] iso
);
    localparam int IDX_W = $clog2(NUM_DOM);

    seq_state_t         state, nxt;
    logic [IDX_W-1:0]   cur, pick;
    logic               dir_up;
    logic [NUM_DOM-1:0] pend;
    logic [CW-1:0]      sw_cyc, iso_cyc;
    logic [TF_W-1:0]    sw_eff, iso_eff;
    logic               hold;

    assign pend    = up_q | dn_q;
    assign sw_eff  = (sw_ticks  == '0) ? TF_W'(1) : sw_ticks;
    assign iso_eff = (iso_ticks == '0) ? TF_W'(1) : iso_ticks;
    assign sw_cyc  = CW'(sw_eff)  * CW'(TICK_DIV) - CW'(1);
    assign iso_cyc = CW'(iso_eff) * CW'(TICK_DIV) - CW'(1);
    assign hold    = dir_up && ((cur == IDX_W'(USB0_BIT) && phy_hold[0]) ||
                                (cur == IDX_W'(USB1_BIT) && phy_hold[1]));

    always_comb begin
        pick = '0;
        for (int i = NUM_DOM - 1; i >= 0; i--)
            if (pend[i]) pick = IDX_W'(i);
    end

    always_comb begin
        nxt      = state;
        load     = 1'b0;
        load_val = sw_cyc;
        clr_up   = '0;
        clr_dn   = '0;
        unique case (state)
            ST_IDLE: if (|pend) begin
                load = 1'b1;
                if (up_q[pick]) begin
                    nxt      = ST_UP_SW;
                    load_val = sw_cyc;
                end else begin
                    nxt      = ST_DN_ISO;
                    load_val = iso_cyc;
                end
            end
            ST_UP_SW: if (expired) begin
                nxt      = ST_UP_ISO;
                load     = 1'b1;
                load_val = iso_cyc;
            end
            ST_UP_ISO: if (expired) nxt = ST_FIN;
            ST_DN_ISO: if (expired) begin
                nxt      = ST_DN_SW;
                load     = 1'b1;
                load_val = sw_cyc;
            end
            ST_DN_SW: if (expired) nxt = ST_FIN;
            ST_FIN: if (!hold) begin
                nxt = ST_IDLE;
                if (dir_up) clr_up[cur] = 1'b1;
                else        clr_dn[cur] = 1'b1;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cur    <= '0;
            dir_up <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && |pend) begin
                cur    <= pick;
                dir_up <= up_q[pick];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_on <= '0;
            iso   <= '1;
        end else begin
            unique case (state)
                ST_IDLE: if (|pend) begin
                    if (up_q[pick]) sw_on[pick] <= 1'b1;
                    else            iso[pick]   <= 1'b1;
                end
                ST_UP_ISO: if (expired) iso[cur]   <= 1'b0;
                ST_DN_ISO: if (expired) sw_on[cur] <= 1'b0;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pgt_ctrl.sv
`timescale 1ns/1ps
module pgt_ctrl
    import pgt_pkg::*;
#(
    parameter int                 NUM_DOM    = 14,
    parameter int                 TICK_DIV   = 4,
    parameter int                 USB0_BIT   = 2,
    parameter int                 USB1_BIT   = 3,
    parameter logic [NUM_DOM-1:0] VALID_MASK = 14'h3FCF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_en,
    input  logic               bus_we,
    input  logic [11:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [1:0]         phy_rst_held,
    output logic [NUM_DOM-1:0] pwr_sw_on,
    output logic [NUM_DOM-1:0] pwr_iso
);
    localparam int CW = TF_W + $clog2(TICK_DIV) + 1;

    logic [NUM_DOM-1:0] up_trig, dn_trig, clr_up, clr_dn;
    logic [TF_W-1:0]    sw_ticks, iso_ticks;
    logic               load, expired;
    logic [CW-1:0]      load_val;

    pgt_regs #(.NUM_DOM(NUM_DOM), .VALID_MASK(VALID_MASK)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .clr_up(clr_up), .clr_dn(clr_dn), .up_q(up_trig), .dn_q(dn_trig),
        .sw_ticks(sw_ticks), .iso_ticks(iso_ticks)
    );

    pgt_delay #(.CW(CW)) u_delay (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
        .expired(expired)
    );

    pgt_seq #(.NUM_DOM(NUM_DOM), .TICK_DIV(TICK_DIV), .USB0_BIT(USB0_BIT),
              .USB1_BIT(USB1_BIT), .CW(CW)) u_seq (
        .clk(clk), .rst_n(rst_n), .up_q(up_trig), .dn_q(dn_trig),
        .sw_ticks(sw_ticks), .iso_ticks(iso_ticks), .phy_hold(phy_rst_held),
        .expired(expired), .load(load), .load_val(load_val),
        .clr_up(clr_up), .clr_dn(clr_dn), .sw_on(pwr_sw_on), .iso(pwr_iso)
    );
endmodule

// File: rtl/pgt_ctrl_chk.sv
`timescale 1ns/1ps
module pgt_ctrl_chk #(
    parameter int                 NUM_DOM    = 14,
    parameter int                 USB0_BIT   = 2,
    parameter int                 USB1_BIT   = 3,
    parameter logic [NUM_DOM-1:0] VALID_MASK = 14'h3FCF
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_DOM-1:0] up_q,
    input logic [NUM_DOM-1:0] dn_q,
    input logic [NUM_DOM-1:0] sw_on,
    input logic [NUM_DOM-1:0] iso,
    input logic [1:0]         phy
);
    p_iso_guard_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((~sw_on) & (~iso)) == '0);

    p_single_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(sw_on ^ $past(sw_on)) + $countones(iso ^ $past(iso))) <= 1);

    p_dead_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((up_q | dn_q) & ~VALID_MASK) == '0);

    p_usb0_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q[USB0_BIT] && phy[0]) |=> up_q[USB0_BIT]);

    p_usb1_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q[USB1_BIT] && phy[1]) |=> up_q[USB1_BIT]);

    p_one_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(($past(up_q) & ~up_q) | ($past(dn_q) & ~dn_q)) <= 1);

    p_up_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(up_q) & ~up_q) & ~(sw_on & ~iso)) == '0);

    p_dn_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(dn_q) & ~dn_q) & (sw_on | ~iso)) == '0);
endmodule

bind pgt_ctrl pgt_ctrl_chk #(
    .NUM_DOM(NUM_DOM), .USB0_BIT(USB0_BIT), .USB1_BIT(USB1_BIT),
    .VALID_MASK(VALID_MASK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .up_q(up_trig), .dn_q(dn_trig),
    .sw_on(pwr_sw_on), .iso(pwr_iso), .phy(phy_rst_held)
);

// File: tb/pgt_ctrl_test.sv
`timescale 1ns/1ps
module pgt_ctrl_test;
    localparam int N   = 14;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  phy_rst_held = '0;
    logic [N-1:0] pwr_sw_on, pwr_iso;

    int compared = 0, mismatched = 0, cyc = 0;

    pgt_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .phy_rst_held(phy_rst_held), .pwr_sw_on(pwr_sw_on), .pwr_iso(pwr_iso)
    );

    always #2.5 clk = ~clk;

    // reference model
    logic [N-1:0] m_up = '0, m_dn = '0, m_sw = '0, m_iso = '1, m_en = '0;
    int  m_swt = 1, m_isot = 1;
    bit  busy = 0, mdir_up = 0;
    int  mcur = 0, t = 0, tot = 0, half = 0;
    localparam logic [N-1:0] VALID = 14'h3FCF;

    always @(posedge clk) begin
        logic [N-1:0] ou, od, cu, cd, sset;
        if (rst_n) begin
            ou = m_up; od = m_dn; cu = '0; cd = '0;
            if (busy) begin
                t++;
                if (mdir_up && t == tot) m_iso[mcur] = 1'b0;
                if (!mdir_up && t == half) m_sw[mcur] = 1'b0;
                if (t >= tot + 1) begin
                    if (mdir_up && ((mcur == 2 && phy_rst_held[0]) || (mcur == 3 && phy_rst_held[1])))
                        t = tot + 1;
                    else begin
                        if (mdir_up) cu[mcur] = 1'b1; else cd[mcur] = 1'b1;
                        busy = 0;
                    end
                end
            end else if ((ou | od) != '0) begin
                int se, ie;
                mcur = 0;
                for (int i = N - 1; i >= 0; i--) if (ou[i] || od[i]) mcur = i;
                mdir_up = ou[mcur];
                se = (m_swt == 0) ? 1 : m_swt;
                ie = (m_isot == 0) ? 1 : m_isot;
                tot = (se + ie) * DIV;
                half = ie * DIV;
                t = 0; busy = 1;
                if (mdir_up) m_sw[mcur] = 1'b1; else m_iso[mcur] = 1'b1;
            end
            sset = '0;
            if (bus_en && bus_we && bus_addr == 12'h000) sset = bus_wdata[N-1:0] & VALID & ~m_en & ~ou;
            m_up = (ou | sset) & ~cu;
            sset = '0;
            if (bus_en && bus_we && bus_addr == 12'h004) sset = bus_wdata[N-1:0] & VALID & m_en & ~od;
            m_dn = (od | sset) & ~cd;
            if (bus_en && bus_we && bus_addr == 12'h008) begin
                m_swt = int'(bus_wdata[6:0]); m_isot = int'(bus_wdata[13:7]);
            end
            for (int i = 0; i < N; i++)
                if (bus_en && bus_we && bus_addr == 12'hC00 + 12'(i) * 12'h040)
                    m_en[i] = bus_wdata[0];
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            check("R4 R5 R11 pwr_sw_on", 32'(pwr_sw_on), 32'(m_sw));
            check("R4 R5 R11 pwr_iso", 32'(pwr_iso), 32'(m_iso));
        end
        if (cyc > 150000) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
        bus_addr = '0;
    endtask

    task automatic wait_done();
        for (int k = 0; k < 2000; k++) begin
            if (!busy && m_up == '0 && m_dn == '0) break;
            @(negedge clk);
        end
    endtask

    // after a write, count negedges until the bit at address a reads 0
    task automatic lat(input logic [11:0] a, input int b, output int n);
        logic [31:0] v;
        n = -1;
        for (int k = 0; k < 2000; k++) begin
            rd(a, v);
            if (!v[b]) begin n = k; break; end
            @(negedge clk);
        end
    endtask

    initial begin
        logic [31:0] v;
        int n;
        int t1, t2, t3;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(12'h000, v); check("R1 up trig", v, 0);
        rd(12'h004, v); check("R1 dn trig", v, 0);
        rd(12'h008, v); check("R1 timing", v, 32'h81);
        rd(12'hC40, v); check("R1 ctrl1", v, 0);
        check("R1 sw_on", 32'(pwr_sw_on), 0);
        check("R1 iso", 32'(pwr_iso), 32'h3FFF);

        // R2 gating by enable bit
        wr(12'h004, 32'h2); rd(12'h004, v); check("R2 dn refused", v, 0);
        wr(12'hC40, 32'h1); rd(12'hC40, v); check("R2 ctrl1 write", v, 1);
        wr(12'h000, 32'h2); rd(12'h000, v); check("R2 up refused", v, 0);
        wr(12'hC40, 32'h0);

        // R3 dead bits
        wr(12'h000, 32'h30); rd(12'h000, v); check("R3 up bits 4,5", v, 0);
        repeat (20) @(negedge clk);
        check("R3 no output change", 32'(pwr_sw_on), 0);

        // R4 R6 power-up latency
        wr(12'h000, 32'h1); rd(12'h000, v); check("R6 bit set while running", v, 1);
        lat(12'h000, 0, n); check("R6 clear latency", n, 2 * DIV + 2);
        check("R4 domain0 on", {30'b0, pwr_sw_on[0], pwr_iso[0]}, 32'b10);

        // R7 ordering of three bits
        wr(12'h000, 32'hE);
        t1 = -1; t2 = -1; t3 = -1;
        for (int k = 0; k < 200; k++) begin
            if (pwr_sw_on[1] && t1 < 0) t1 = k;
            if (pwr_sw_on[2] && t2 < 0) t2 = k;
            if (pwr_sw_on[3] && t3 < 0) t3 = k;
            @(negedge clk);
        end
        check("R7 ascending order", {30'b0, (t1 < t2), (t2 < t3)}, 32'b11);

        // R8 rewrite and zero write
        wr(12'h000, 32'h40);
        wr(12'h000, 32'h40);
        wr(12'h000, 32'h0);
        rd(12'h000, v); check("R8 still pending", v, 32'h40);
        wait_done();
        check("R8 domain6 on", 32'(pwr_sw_on[6]), 1);

        // R9 USB hold
        phy_rst_held = 2'b01;
        wr(12'h000, 32'h4);
        repeat (40) @(negedge clk);
        rd(12'h000, v); check("R9 held bit2", v, 32'h4);
        phy_rst_held = 2'b00;
        repeat (3) @(negedge clk);
        rd(12'h000, v); check("R9 released bit2", v, 0);

        // R5 power-down
        wr(12'hC40, 32'h1);
        wr(12'h004, 32'h2);
        lat(12'h004, 1, n); check("R5 dn latency", n, 2 * DIV + 2);
        check("R5 domain1 off", {30'b0, pwr_sw_on[1], pwr_iso[1]}, 32'b01);

        // R10 timing fields
        wr(12'h008, 32'h0); rd(12'h008, v); check("R10 timing zero", v, 0);
        wr(12'hC40, 32'h0);
        wr(12'h000, 32'h2);
        lat(12'h000, 1, n); check("R10 zero as one tick", n, 2 * DIV + 2);
        wr(12'h008, 32'h103); rd(12'h008, v); check("R10 timing readback", v, 32'h103);
        wr(12'hC00, 32'h1);
        wr(12'h004, 32'h1);
        lat(12'h004, 0, n); check("R10 longer latency", n, 5 * DIV + 2);

        // R7 up before down on one bit
        wr(12'h000, 32'h180);
        wr(12'hE00, 32'h1);
        wr(12'h004, 32'h100);
        rd(12'h004, v); check("R7 dn pending", v, 32'h100);
        wait_done();
        check("R7 domain8 final off", {30'b0, pwr_sw_on[8], pwr_iso[8]}, 32'b01);
        check("R7 domain7 on", 32'(pwr_sw_on[7]), 1);

        repeat (5) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule